// File: doc/BRIEF.md
# Two-Port Semaphore Token Unit

This block holds a small bank of hardware semaphores that two independent ports, called left and right, use to agree on who owns a shared resource. Each port picks one semaphore with a short address. Writing a 0 on data bit 0 asks for the token and writing a 1 gives it back. A read returns that port's view of the chosen semaphore on every data line: all zeros when this port owns the token, all ones otherwise.

A port that asks for a token held by the other port does not need to poll. Its request is recorded as pending. When the holder releases, ownership moves straight to the waiting port in the same clock edge. If both ports ask for a free semaphore in the same cycle, the left port wins and the right port's request is kept pending. Writes take effect on the rising clock edge. Reads are combinational from the registered state and the port's current address.

Top module: `sem_token_unit`

## Requirements
- R1: There are SEM_COUNT (default 8) semaphores, chosen by the port address. A write to one semaphore leaves every other semaphore unchanged. The two ports may act on different semaphores in the same cycle.
- R2: A write uses only data bit 0 (0 = request, 1 = release), and the other data bits are ignored. A read drives the port's status on all DATA_W data lines: 0x00 when this port holds the token, 0xFF otherwise.
- R3: After reset every semaphore is free with no pending request, and both ports read 0xFF at every address.
- R4: A request to a free semaphore grants it to the requesting port at the next edge. That port then reads 0x00 and the other port reads 0xFF. The two ports never hold the same semaphore at once.
- R5: A request from the non-holder does not change ownership; it is recorded as pending.
- R6: A release by the holder while the other port has a pending request hands the token to the other port at that edge. The new holder reads 0x00 and the former holder reads 0xFF.
- R7: A release by the holder with no pending request frees the semaphore, and both ports read 0xFF.
- R8: When both ports request the same free semaphore in the same cycle, the left port gets the token and the right port's request becomes pending.
- R9: A release by a port that neither holds nor has requested the semaphore has no effect. A release by a non-holder with a pending request withdraws that request, so a later release by the holder frees the semaphore.
- R10: A repeated request by the current holder has no effect on ownership.
- R11: A write happens only when both the port's select and write enable are high. Any other combination changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port select |
| l_we | input | 1 | Left port write enable |
| l_addr | input | ADDR_W (3) | Left port semaphore address |
| l_wdata | input | DATA_W (8) | Left port write data; only bit 0 is used |
| l_rdata | output | DATA_W (8) | Left port status of the addressed semaphore |
| r_sel | input | 1 | Right port select |
| r_we | input | 1 | Right port write enable |
| r_addr | input | ADDR_W (3) | Right port semaphore address |
| r_wdata | input | DATA_W (8) | Right port write data; only bit 0 is used |
| r_rdata | output | DATA_W (8) | Right port status of the addressed semaphore |

## Verification
The assertions assume that select, write enable, address and bit 0 of the write data are known and stable around each rising edge. They also assume that each port issues at most one write per cycle. The bench drives every input on the falling edge and returns select and write enable to zero after each single write cycle. It reads status only after the edge has settled, so each property sees clean, one-cycle request and release strobes. Simultaneous writes from both ports are issued deliberately, both to the same semaphore and to different semaphores, so that the tie and independence cases happen at a single edge.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic {
        PORT_L = 1'b0,
        PORT_R = 1'b1
    } port_e;

    typedef struct packed {
        logic  held;
        port_e owner;
        logic  pend;
    } sem_state_t;

    localparam sem_state_t SEM_FREE = '{held: 1'b0, owner: PORT_L, pend: 1'b0};

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int SEM_COUNT = 8,
    parameter int ADDR_W    = $clog2(SEM_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wbit,
    output logic [SEM_COUNT-1:0] take,
    output logic [SEM_COUNT-1:0] give
);

    logic wr_en;

    always_comb begin
        wr_en = sel & we;
        take  = '0;
        give  = '0;
        for (int i = 0; i < SEM_COUNT; i++) begin
            if (wr_en && (int'(addr) == i)) begin
                take[i] = ~wbit;
                give[i] = wbit;
            end
        end
    end

    // R1: one write reaches at most one semaphore, as either a request or a release
    p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take | give) && ((take & give) == '0));

    // R11: without select and write enable, no semaphore sees a strobe
    p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && we) |-> ((take | give) == '0));

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_take,
    input  logic l_give,
    input  logic r_take,
    input  logic r_give,
    output logic l_owns,
    output logic r_owns
);

    sem_state_t st_d, st_q;
    logic  hold_give;
    logic  oth_take;
    logic  oth_give;
    logic  pend_eff;
    port_e other;

    always_comb begin
        st_d      = st_q;
        other     = port_e'(~st_q.owner);
        hold_give = (st_q.owner == PORT_L) ? l_give : r_give;
        oth_take  = (st_q.owner == PORT_L) ? r_take : l_take;
        oth_give  = (st_q.owner == PORT_L) ? r_give : l_give;
        pend_eff  = (st_q.pend | oth_take) & ~oth_give;

        if (!st_q.held) begin
            if (l_take) begin
                st_d.held  = 1'b1;
                st_d.owner = PORT_L;
                st_d.pend  = r_take;
            end else if (r_take) begin
                st_d.held  = 1'b1;
                st_d.owner = PORT_R;
                st_d.pend  = 1'b0;
            end
        end else if (hold_give) begin
            if (pend_eff) begin
                st_d.owner = other;
                st_d.pend  = 1'b0;
            end else begin
                st_d.held  = 1'b0;
                st_d.pend  = 1'b0;
            end
        end else begin
            st_d.pend = pend_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEM_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    assign l_owns = st_q.held && (st_q.owner == PORT_L);
    assign r_owns = st_q.held && (st_q.owner == PORT_R);

    // R5: a pending request exists only while the token is held
    p_pend_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> st_q.held);

    // R5: without a release by the holder, ownership stays put
    p_keep_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !hold_give) |=> (st_q.held && $stable(st_q.owner)));

    // R6: release with a pending request that is not withdrawn hands the token over
    p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && st_q.pend && hold_give && !oth_give)
        |=> (st_q.held && (st_q.owner != $past(st_q.owner)) && !st_q.pend));

    // R7: release with nobody waiting frees the semaphore
    p_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !st_q.pend && hold_give && !oth_take) |=> !st_q.held);

    // R8: a tie on a free semaphore goes to the left port, the right one waits
    p_tie_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.held && l_take && r_take)
        |=> (st_q.held && st_q.owner == PORT_L && st_q.pend));

endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit #(
    parameter  int SEM_COUNT = 8,
    parameter  int DATA_W    = 8,
    localparam int ADDR_W    = $clog2(SEM_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    logic [SEM_COUNT-1:0] l_take, l_give, r_take, r_give;
    logic [SEM_COUNT-1:0] l_owns, r_owns;
    logic                 l_stat, r_stat;

    sem_port_decode #(.SEM_COUNT(SEM_COUNT), .ADDR_W(ADDR_W)) u_dec_l (
        .clk(clk), .rst_n(rst_n), .sel(l_sel), .we(l_we), .addr(l_addr),
        .wbit(l_wdata[0]), .take(l_take), .give(l_give)
    );

    sem_port_decode #(.SEM_COUNT(SEM_COUNT), .ADDR_W(ADDR_W)) u_dec_r (
        .clk(clk), .rst_n(rst_n), .sel(r_sel), .we(r_we), .addr(r_addr),
        .wbit(r_wdata[0]), .take(r_take), .give(r_give)
    );

    for (genvar g = 0; g < SEM_COUNT; g++) begin : g_sem
        sem_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .l_take(l_take[g]),
            .l_give(l_give[g]),
            .r_take(r_take[g]),
            .r_give(r_give[g]),
            .l_owns(l_owns[g]),
            .r_owns(r_owns[g])
        );
    end

    always_comb begin
        l_stat  = ~l_owns[l_addr];
        r_stat  = ~r_owns[r_addr];
        l_rdata = {DATA_W{l_stat}};
        r_rdata = {DATA_W{r_stat}};
    end

    // R4: the two ports never hold the same semaphore together
    p_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_owns & r_owns) == '0);

    // R11: with neither port writing, no semaphore changes owner
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(l_sel && l_we) && !(r_sel && r_we)) |=> ($stable(l_owns) && $stable(r_owns)));

endmodule

// File: tb/sim_sem_token_unit.sv
module sim_sem_token_unit;

    localparam int SEMS = 8;
    localparam int DW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sel = 1'b0, l_we = 1'b0, r_sel = 1'b0, r_we = 1'b0;
    logic [2:0]    l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    sem_token_unit #(.SEM_COUNT(SEMS), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    // One write cycle; each side active when its enable argument is set.
    task automatic wr(input bit le, input int la, input logic [DW-1:0] ld,
                      input bit re, input int ra, input logic [DW-1:0] rd);
        @(negedge clk);
        l_sel = le; l_we = le; l_addr = 3'(la); l_wdata = ld;
        r_sel = re; r_we = re; r_addr = 3'(ra); r_wdata = rd;
        @(negedge clk);
        l_sel = 1'b0; l_we = 1'b0; r_sel = 1'b0; r_we = 1'b0;
        #1;
    endtask

    // Expected status: 1 means not holding (0xFF), 0 means holding (0x00).
    task automatic chk(input string req, input int a, input bit exp_l, input bit exp_r);
        logic [DW-1:0] el, er;
        l_addr = 3'(a); r_addr = 3'(a);
        #1;
        el = {DW{exp_l}};
        er = {DW{exp_r}};
        total++;
        if (l_rdata !== el) begin
            bad++;
            $display("FAIL %s left sem %0d: got %h expected %h", req, a, l_rdata, el);
        end
        total++;
        if (r_rdata !== er) begin
            bad++;
            $display("FAIL %s right sem %0d: got %h expected %h", req, a, r_rdata, er);
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < SEMS; i++) chk("R3", i, 1'b1, 1'b1);
    endtask

    task automatic t_take_release;
        wr(1, 3, 8'hFE, 0, 0, 8'h00);           // R2: upper bits set, bit 0 clear = request
        chk("R4", 3, 1'b0, 1'b1);
        for (int i = 0; i < SEMS; i++) if (i != 3) chk("R1", i, 1'b1, 1'b1);
        wr(1, 3, 8'h01, 0, 0, 8'h00);
        chk("R7", 3, 1'b1, 1'b1);
        wr(0, 0, 8'h00, 1, 3, 8'hAA);           // R2: 0xAA has bit 0 clear
        chk("R2", 3, 1'b1, 1'b0);
        wr(0, 0, 8'h00, 1, 3, 8'h55);
        chk("R7", 3, 1'b1, 1'b1);
    endtask

    task automatic t_pending;
        wr(1, 5, 8'h00, 0, 0, 8'h00);
        wr(0, 0, 8'h00, 1, 5, 8'h00);
        chk("R5", 5, 1'b0, 1'b1);
        wr(1, 5, 8'h01, 0, 0, 8'h00);
        chk("R6", 5, 1'b1, 1'b0);
        wr(0, 0, 8'h00, 1, 5, 8'h01);
        chk("R7", 5, 1'b1, 1'b1);
    endtask

    task automatic t_tie;
        wr(1, 2, 8'h00, 1, 2, 8'h00);
        chk("R8", 2, 1'b0, 1'b1);
        wr(1, 2, 8'h01, 0, 0, 8'h00);
        chk("R8", 2, 1'b1, 1'b0);
        wr(0, 0, 8'h00, 1, 2, 8'h01);
        chk("R7", 2, 1'b1, 1'b1);
    endtask

    task automatic t_withdraw;
        wr(0, 0, 8'h00, 1, 6, 8'h01);           // release of a free semaphore
        chk("R9", 6, 1'b1, 1'b1);
        wr(1, 1, 8'h00, 0, 0, 8'h00);
        wr(0, 0, 8'h00, 1, 1, 8'h01);           // non-holder, no request
        chk("R9", 1, 1'b0, 1'b1);
        wr(0, 0, 8'h00, 1, 1, 8'h00);           // request pending
        wr(0, 0, 8'h00, 1, 1, 8'h01);           // withdraw it
        chk("R9", 1, 1'b0, 1'b1);
        wr(1, 1, 8'h01, 0, 0, 8'h00);
        chk("R9", 1, 1'b1, 1'b1);
    endtask

    task automatic t_retake;
        wr(1, 4, 8'h00, 0, 0, 8'h00);
        wr(1, 4, 8'h00, 0, 0, 8'h00);
        chk("R10", 4, 1'b0, 1'b1);
        wr(0, 0, 8'h00, 1, 4, 8'h00);
        wr(1, 4, 8'h00, 0, 0, 8'h00);
        chk("R10", 4, 1'b0, 1'b1);
        wr(1, 4, 8'h01, 0, 0, 8'h00);
        chk("R6", 4, 1'b1, 1'b0);
        wr(0, 0, 8'h00, 1, 4, 8'h01);
        chk("R7", 4, 1'b1, 1'b1);
    endtask

    task automatic t_nosel;
        @(negedge clk);
        l_sel = 1'b0; l_we = 1'b1; l_addr = 3'd0; l_wdata = 8'h00;
        r_sel = 1'b1; r_we = 1'b0; r_addr = 3'd0; r_wdata = 8'h00;
        @(negedge clk);
        l_we = 1'b0; r_sel = 1'b0;
        #1;
        chk("R11", 0, 1'b1, 1'b1);
    endtask

    task automatic t_independent;
        wr(1, 0, 8'h00, 1, 7, 8'h00);
        chk("R1", 0, 1'b0, 1'b1);
        chk("R1", 7, 1'b1, 1'b0);
        wr(1, 0, 8'h01, 1, 7, 8'h01);
        chk("R1", 0, 1'b1, 1'b1);
        chk("R1", 7, 1'b1, 1'b1);
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_take_release();
        t_pending();
        t_tie();
        t_withdraw();
        t_retake();
        t_nosel();
        t_independent();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule